// File: doc/BRIEF.md
# Circular Branch Trace Buffer

This block keeps a short history of the most recent branches so that software can look at the path that led to a point of interest. A branch event can produce one or two log entries. A source entry holds the branch's own address and two prediction flags: whether it was predicted taken, and whether it was mispredicted. A target entry holds the address the branch went to. Entries go into a ring of eight slots under a write pointer that wraps, so each new entry overwrites the oldest one.

Software reads any slot, or a status word holding the pointer, through a combinational select-and-read port. A freeze request stops all logging and stays in force, so the path before a captured event is kept intact. One control write clears the freeze, empties the ring, returns the pointer to zero and chooses whether only mispredicted branches are logged.

Top module: `brtrace_ring`

## Requirements
- R1: After reset every slot reads as zero, the status word reads zero and the mispredict-only mode is off.
- R2: An accepted event with `br_valid`=1 and `br_tgt_valid`=0 writes one entry into slot `ptr`: bit AW+3 valid=1, bit AW+2 kind=0 (source), bit AW+1 predicted-taken, bit AW mispredicted, low AW bits the branch address. The pointer then advances by one.
- R3: An accepted event with `br_tgt_valid`=1 writes the source entry into slot `ptr` and a target entry into slot `ptr+1` in the same cycle. The target entry has valid=1, kind=1, both prediction bits 0 and the target address in the low bits. The pointer advances by two.
- R4: The pointer wraps from 7 to 0, so a pair written from slot 7 uses slots 7 and 0, and new entries overwrite the oldest ones.
- R5: While mispredict-only mode is on, an event with `br_mispred`=0 writes nothing and leaves the pointer unchanged.
- R6: `freeze_in` blocks the write of the event in its own cycle and sets a sticky frozen flag. While that flag is set, no event changes any slot or the pointer.
- R7: A cycle with `ctl_we`=1 clears the frozen flag, zeroes every slot, sets the pointer to 0 and loads the mode from `ctl_misp_only`. Any branch event in that same cycle is dropped.
- R8: `rd_sel` values 0 to 7 return slots 0 to 7. Value 8 returns the status word: frozen at bit 4, mode at bit 3, pointer at bits 2:0, all other bits 0. Values 9 to 15 return zero.
- R9: `br_tgt_valid` without `br_valid` writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch event present |
| br_addr | input | 16 | Branch address |
| br_pred_taken | input | 1 | Branch was predicted taken |
| br_mispred | input | 1 | Branch was mispredicted |
| br_tgt_valid | input | 1 | Also log the target entry |
| br_tgt_addr | input | 16 | Target address |
| freeze_in | input | 1 | Freeze request, sticky |
| ctl_we | input | 1 | Control register write |
| ctl_misp_only | input | 1 | Mode value loaded by a control write |
| rd_sel | input | 4 | Read select: slot, status or unused |
| rd_data | output | 20 | Read data |

## Verification
The first collision is a branch event in the same cycle as a freeze request. The second is a branch event in the same cycle as a control write. In both cases the event must be lost, while the freeze, or the clear and mode load, takes effect. The bench forces each collision on purpose, then reads back all eight slots and the status word. These are compared with a model that applies the priority control write, then freeze, then logging. Source and target pairs that start at slot 7 are compared the same way, to judge the wrap of a double write.

// File: rtl/brt_pkg.sv
package brt_pkg;
    typedef enum logic {
        KIND_SRC = 1'b0,
        KIND_TGT = 1'b1
    } ent_kind_e;

    typedef struct packed {
        logic      valid;
        ent_kind_e kind;
        logic      pred_taken;
        logic      mispred;
    } ent_hdr_t;

    localparam int HDR_W = 4;

    function automatic ent_hdr_t mk_src_hdr(input logic taken, input logic misp);
        ent_hdr_t h;
        h.valid      = 1'b1;
        h.kind       = KIND_SRC;
        h.pred_taken = taken;
        h.mispred    = misp;
        return h;
    endfunction

    function automatic ent_hdr_t mk_tgt_hdr();
        ent_hdr_t h;
        h.valid      = 1'b1;
        h.kind       = KIND_TGT;
        h.pred_taken = 1'b0;
        h.mispred    = 1'b0;
        return h;
    endfunction
endpackage

// File: rtl/brt_ctl.sv
module brt_ctl (
    input  logic clk,
    input  logic rst,
    input  logic freeze_in,
    input  logic ctl_we,
    input  logic ctl_misp_only,
    output logic frozen_q,
    output logic misp_only_q,
    output logic block,
    output logic clear
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frozen_q    <= 1'b0;
            misp_only_q <= 1'b0;
        end else if (ctl_we) begin
            frozen_q    <= 1'b0;
            misp_only_q <= ctl_misp_only;
        end else if (freeze_in) begin
            frozen_q    <= 1'b1;
        end
    end

    // A control write wins over freeze, and freeze wins over logging.
    assign block = frozen_q | freeze_in | ctl_we;
    assign clear = ctl_we;
endmodule

// File: rtl/brt_filter.sv
module brt_filter
    import brt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          br_valid,
    input  logic [AW-1:0] br_addr,
    input  logic          br_pred_taken,
    input  logic          br_mispred,
    input  logic          br_tgt_valid,
    input  logic [AW-1:0] br_tgt_addr,
    input  logic          misp_only,
    input  logic          block,
    output logic [1:0]    wr_cnt,
    output ent_hdr_t      hdr0,
    output logic [AW-1:0] addr0,
    output ent_hdr_t      hdr1,
    output logic [AW-1:0] addr1
);
    logic accept;

    always_comb begin
        accept = br_valid && !block && (!misp_only || br_mispred);
        wr_cnt = accept ? (br_tgt_valid ? 2'd2 : 2'd1) : 2'd0;
        hdr0   = mk_src_hdr(br_pred_taken, br_mispred);
        addr0  = br_addr;
        hdr1   = mk_tgt_hdr();
        addr1  = br_tgt_addr;
    end
endmodule

// File: rtl/brt_store.sv
module brt_store
    import brt_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [1:0]    wr_cnt,
    input  ent_hdr_t      hdr0,
    input  logic [AW-1:0] addr0,
    input  ent_hdr_t      hdr1,
    input  logic [AW-1:0] addr1,
    output logic [PW-1:0] ptr_q,
    output ent_hdr_t      hdr_q  [DEPTH],
    output logic [AW-1:0] addr_q [DEPTH]
);
    logic [PW-1:0] ptr_nxt1;

    assign ptr_nxt1 = ptr_q + PW'(1);

    always_ff @(posedge clk) begin
        if (rst || clear) ptr_q <= '0;
        else              ptr_q <= ptr_q + PW'(wr_cnt);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                hdr_q[i]  <= '0;
                addr_q[i] <= '0;
            end else if (wr_cnt != 2'd0 && ptr_q == PW'(i)) begin
                hdr_q[i]  <= hdr0;
                addr_q[i] <= addr0;
            end else if (wr_cnt == 2'd2 && ptr_nxt1 == PW'(i)) begin
                hdr_q[i]  <= hdr1;
                addr_q[i] <= addr1;
            end
        end
    end
endmodule

// File: rtl/brtrace_ring.sv
module brtrace_ring
    import brt_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int SW   = PW + 1,
    localparam int RDW  = AW + HDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           br_valid,
    input  logic [AW-1:0]  br_addr,
    input  logic           br_pred_taken,
    input  logic           br_mispred,
    input  logic           br_tgt_valid,
    input  logic [AW-1:0]  br_tgt_addr,
    input  logic           freeze_in,
    input  logic           ctl_we,
    input  logic           ctl_misp_only,
    input  logic [SW-1:0]  rd_sel,
    output logic [RDW-1:0] rd_data
);
    logic          frozen_q, misp_only_q, block, clear;
    logic [1:0]    wr_cnt;
    ent_hdr_t      hdr0, hdr1;
    logic [AW-1:0] addr0, addr1;
    logic [PW-1:0] ptr_q;
    ent_hdr_t      hdr_q  [DEPTH];
    logic [AW-1:0] addr_q [DEPTH];
    logic [DEPTH-1:0] kind_vec;

    brt_ctl u_ctl (
        .clk(clk), .rst(rst), .freeze_in(freeze_in), .ctl_we(ctl_we),
        .ctl_misp_only(ctl_misp_only), .frozen_q(frozen_q),
        .misp_only_q(misp_only_q), .block(block), .clear(clear)
    );

    brt_filter #(.AW(AW)) u_filter (
        .br_valid(br_valid), .br_addr(br_addr), .br_pred_taken(br_pred_taken),
        .br_mispred(br_mispred), .br_tgt_valid(br_tgt_valid),
        .br_tgt_addr(br_tgt_addr), .misp_only(misp_only_q), .block(block),
        .wr_cnt(wr_cnt), .hdr0(hdr0), .addr0(addr0), .hdr1(hdr1), .addr1(addr1)
    );

    brt_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .clear(clear), .wr_cnt(wr_cnt),
        .hdr0(hdr0), .addr0(addr0), .hdr1(hdr1), .addr1(addr1),
        .ptr_q(ptr_q), .hdr_q(hdr_q), .addr_q(addr_q)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_kind
        assign kind_vec[i] = hdr_q[i].kind;
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel < SW'(DEPTH)) begin
            rd_data = {hdr_q[rd_sel[PW-1:0]], addr_q[rd_sel[PW-1:0]]};
        end else if (rd_sel == SW'(DEPTH)) begin
            rd_data = RDW'({frozen_q, misp_only_q, ptr_q});
        end
    end
endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             br_valid,
    input logic             br_mispred,
    input logic             freeze_in,
    input logic             ctl_we,
    input logic             frozen,
    input logic             misp_only,
    input logic [1:0]       wr_cnt,
    input logic [PW-1:0]    ptr,
    input logic [DEPTH-1:0] kind_vec
);
    assert_frozen_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (frozen && !ctl_we) |=> $stable(ptr));

    assert_freeze_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (freeze_in && !ctl_we) |=> frozen);

    assert_ctl_clears_R7: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ptr == '0 && !frozen));

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        !ctl_we |=> (PW'(ptr - $past(ptr)) <= PW'(2)));

    assert_mode_filter_R5: assert property (@(posedge clk) disable iff (rst)
        (misp_only && br_valid && !br_mispred && !ctl_we) |=> $stable(ptr));

    assert_no_lone_target_R9: assert property (@(posedge clk) disable iff (rst)
        (!br_valid && !ctl_we) |=> $stable(ptr));

    assert_pair_order_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt == 2'd2) |=> (kind_vec[$past(ptr)] == 1'b0 &&
                              kind_vec[PW'($past(ptr) + PW'(1))] == 1'b1));
endmodule

bind brtrace_ring brt_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_mispred(br_mispred),
    .freeze_in(freeze_in), .ctl_we(ctl_we), .frozen(frozen_q),
    .misp_only(misp_only_q), .wr_cnt(wr_cnt), .ptr(ptr_q), .kind_vec(kind_vec)
);

// File: tb/tb_brtrace_ring.sv
`timescale 1ns/100ps
module tb_brtrace_ring;
    localparam int AW = 16, DEPTH = 8, PW = 3, SW = 4, RDW = AW + 4;

    logic clk = 1'b0, rst = 1'b1;
    logic br_valid = 0, br_pred_taken = 0, br_mispred = 0, br_tgt_valid = 0;
    logic [AW-1:0] br_addr = '0, br_tgt_addr = '0;
    logic freeze_in = 0, ctl_we = 0, ctl_misp_only = 0;
    logic [SW-1:0] rd_sel = '0;
    logic [RDW-1:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [RDW-1:0] m_ent [DEPTH];
    logic [PW-1:0]  m_ptr;
    logic           m_frz, m_mode;
    logic [15:0]    lfsr = 16'hACE1;

    always #2 clk = ~clk;

    brtrace_ring dut (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_addr(br_addr),
        .br_pred_taken(br_pred_taken), .br_mispred(br_mispred),
        .br_tgt_valid(br_tgt_valid), .br_tgt_addr(br_tgt_addr),
        .freeze_in(freeze_in), .ctl_we(ctl_we), .ctl_misp_only(ctl_misp_only),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [RDW-1:0] act,
                         input logic [RDW-1:0] exp, input int sel);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, act, exp);
        end
    endtask

    // Reads every slot, the status word and the unused selects.
    task automatic check_all(input string req);
        for (int s = 0; s < 16; s++) begin
            logic [RDW-1:0] e;
            rd_sel = SW'(s);
            #0.1;
            if (s < DEPTH)       e = m_ent[s];
            else if (s == DEPTH) e = RDW'({m_frz, m_mode, m_ptr});
            else                 e = '0;
            check(req, rd_data, e, s);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_ent[i] = '0;
        m_ptr = '0; m_frz = 0; m_mode = 0;
    endtask

    task automatic step(input logic bv, input logic tp, input logic mp,
                        input logic tv, input logic [AW-1:0] sa,
                        input logic [AW-1:0] ta, input logic fz,
                        input logic cw, input logic cm, input string req);
        @(negedge clk);
        br_valid = bv; br_pred_taken = tp; br_mispred = mp; br_tgt_valid = tv;
        br_addr = sa; br_tgt_addr = ta; freeze_in = fz; ctl_we = cw;
        ctl_misp_only = cm;
        @(posedge clk);
        if (cw) begin
            for (int i = 0; i < DEPTH; i++) m_ent[i] = '0;
            m_ptr = '0; m_frz = 0; m_mode = cm;
        end else begin
            if (!m_frz && !fz && bv && (!m_mode || mp)) begin
                m_ent[m_ptr] = {1'b1, 1'b0, tp, mp, sa};
                m_ptr = m_ptr + 3'd1;
                if (tv) begin
                    m_ent[m_ptr] = {1'b1, 1'b1, 2'b00, ta};
                    m_ptr = m_ptr + 3'd1;
                end
            end
            if (fz) m_frz = 1;
        end
        #0.2;
        br_valid = 0; br_tgt_valid = 0; freeze_in = 0; ctl_we = 0;
        check_all(req);
    endtask

    task automatic rnd_step(input string req, input logic fz);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(1'b1, lfsr[0], lfsr[1], lfsr[2], lfsr ^ 16'h1234, ~lfsr, fz, 1'b0, 1'b0, req);
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check_all("R1 reset and R8 read map");

        // R2 single source entries, then R3 pairs, walking across the wrap (R4).
        for (int i = 0; i < 10; i++)
            step(1'b1, i[0], i[1], 1'b0, AW'(16'h100 + i), '0, 0, 0, 0, "R2 single entry / R4 wrap");
        for (int i = 0; i < 9; i++)
            step(1'b1, i[1], i[0], 1'b1, AW'(16'h200 + i), AW'(16'h300 + i), 0, 0, 0, "R3 pair / R4 wrap");
        // R4 pair starting at slot 7: reach ptr 7 first.
        step(0, 0, 0, 0, '0, '0, 0, 1, 0, "R7 clear");
        for (int i = 0; i < 7; i++)
            step(1'b1, 0, 0, 0, AW'(16'h400 + i), '0, 0, 0, 0, "R2 fill to slot 7");
        step(1'b1, 1, 1, 1, 16'hBEEF, 16'hCAFE, 0, 0, 0, "R4 pair across slot 7 to 0");
        // Mixed random events.
        for (int i = 0; i < 40; i++) rnd_step("R2 R3 random mix", 1'b0);
        // R9 target without branch.
        step(1'b0, 1, 1, 1, 16'h5555, 16'h6666, 0, 0, 0, "R9 lone target");
        // R5 mispredict-only mode.
        step(0, 0, 0, 0, '0, '0, 0, 1, 1, "R7 mode load");
        for (int i = 0; i < 30; i++) rnd_step("R5 mispredict-only mode", 1'b0);
        // R7 control write colliding with an event.
        step(1'b1, 1, 1, 1, 16'h7777, 16'h8888, 0, 1, 0, "R7 event dropped on control write");
        for (int i = 0; i < 5; i++) rnd_step("R2 R3 after mode off", 1'b0);
        // R6 freeze colliding with an event, then held.
        step(1'b1, 1, 0, 1, 16'h9999, 16'hAAAA, 1, 0, 0, "R6 event dropped with freeze");
        for (int i = 0; i < 10; i++) rnd_step("R6 frozen holds", 1'b0);
        step(0, 0, 0, 0, '0, '0, 1, 1, 0, "R7 control write beats freeze");
        for (int i = 0; i < 12; i++) rnd_step("R2 R3 after unfreeze", 1'b0);
        rnd_step("R6 random freeze", 1'b1);
        rnd_step("R6 still frozen", 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule